// File: doc/BRIEF.md
# Floating-Point Predicate Compare Unit

This block compares two floating-point operands of one precision, either single (32-bit) or double (64-bit), under a predicate chosen by a 4-bit code. Each predicate states plainly what it returns when an operand is NaN ("unordered"). In mask mode, a true predicate writes an all-ones mask of the operand's register width and a false one writes all zeros. The mask can then drive a bitwise select directly. In condition mode, the same predicate result is written to a single condition bit instead, and the mask register is left untouched.

One request is taken per cycle when `in_valid` is high. The result is registered and appears one clock later with `out_valid`. A NaN is any value whose exponent field is all ones and whose fraction is nonzero. Ordering uses sign and magnitude, and the two zeros are equal. Raising exceptions on NaN operands and writing the result back to a register file are left to the surrounding logic.

Top module: `fp_pred_cmp`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, so the latency is one clock.
- R2: In mask mode (`cond_mode`=0), a true result writes all 64 ones when `prec_dbl`=1. When `prec_dbl`=0, it writes ones in bits 31:0 and zeros in bits 63:32. A false result writes all zeros. Single operands sit in bits 31:0 of `op_a`/`op_b`, and bits 63:32 are ignored.
- R3: Code 0 (always-false) gives a false result for every operand pair, including NaNs.
- R4: Code 1 (unordered) is true when at least one operand is NaN. Code 9 (ordered) is true only when neither operand is NaN.
- R5: Codes 2 (equal), 4 (less) and 6 (less-or-equal) test a compared to b, and are false whenever either operand is NaN.
- R6: Codes 3, 5 and 7 are true when a equals b, a is less than b, or a is less than or equal to b respectively. They are also true when either operand is NaN.
- R7: Code 10 is true when the operands differ or either is NaN. Code 11 is true only when both are non-NaN and differ.
- R8: +0 and -0 compare equal under every predicate.
- R9: Ordering follows the real value: negative numbers are below positive ones, a larger magnitude is lower among negatives, and infinities are the extremes.
- R10: Codes 8 and 12 to 15 give a false result.
- R11: In condition mode (`cond_mode`=1), `cond_out` takes the predicate result one cycle after the request, and `mask_out` keeps its previous value.
- R12: A mask-mode request leaves `cond_out` unchanged. A cycle without `in_valid` leaves both `mask_out` and `cond_out` unchanged.
- R13: After reset, `out_valid`, `mask_out` and `cond_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| prec_dbl | input | 1 | 1 = double precision, 0 = single precision in bits 31:0 |
| pred | input | 4 | Predicate code |
| cond_mode | input | 1 | 1 = write the condition bit, 0 = write the mask |
| op_a | input | 64 | First operand (left side of the relation) |
| op_b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| mask_out | output | 64 | Registered result mask |
| cond_out | output | 1 | Registered condition bit |

## Verification
All sixteen predicate codes are swept over several kinds of operand pair:
- **Ordered pairs with a < b, a = b and a > b.** These separate the strict, non-strict and equality predicates.
- **Pairs with a quiet or signalling NaN on either side.** These separate the ordered forms from the unordered ones.
- **Pairs of mixed-sign values, infinities and the two signed zeros.** These show whether the ordering is sign-magnitude or plain two's-complement, and whether -0 equals +0.
- **Single-precision requests with junk in the upper half of each operand.** These show that the upper bits are ignored and that the mask stops at bit 31.
- **Condition-mode requests between mask-mode requests, and idle cycles.** These show which result register each mode may touch.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  localparam int EXP_D = 11;
  localparam int MAN_D = 52;
  localparam int EXP_S = 8;
  localparam int MAN_S = 23;

  typedef enum logic [3:0] {
    P_NEVER = 4'd0,
    P_UNORD = 4'd1,
    P_EQ    = 4'd2,
    P_UEQ   = 4'd3,
    P_LT    = 4'd4,
    P_ULT   = 4'd5,
    P_LE    = 4'd6,
    P_ULE   = 4'd7,
    P_ORD   = 4'd9,
    P_UNE   = 4'd10,
    P_NE    = 4'd11
  } pred_code_e;

  typedef struct packed {
    logic nan;
    logic zero;
    logic sign;
  } fp_cls_t;

endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
  import fpcmp_pkg::*;
#(
  parameter int EW    = 11,
  parameter int MW    = 52,
  parameter int OUT_W = 63
) (
  input  logic [EW+MW:0]   word,
  output fp_cls_t          cls,
  output logic [OUT_W-1:0] mag
);

  localparam int MAGW = EW + MW;

  logic [EW-1:0] expf;
  logic [MW-1:0] frac;

  assign expf = word[MAGW-1:MW];
  assign frac = word[MW-1:0];

  always_comb begin
    cls.sign = word[MAGW];
    cls.nan  = (&expf) && (|frac);
    cls.zero = ~|word[MAGW-1:0];
  end

  generate
    if (OUT_W > MAGW) begin : g_ext
      assign mag = {{(OUT_W-MAGW){1'b0}}, word[MAGW-1:0]};
    end else begin : g_same
      assign mag = word[MAGW-1:0];
    end
  endgenerate

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  fp_cls_t          cls_a,
  input  fp_cls_t          cls_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output logic             eq,
  output logic             lt
);

  logic mag_lt, mag_gt, mag_eq, both_zero;

  assign mag_lt    = mag_a < mag_b;
  assign mag_gt    = mag_a > mag_b;
  assign mag_eq    = mag_a == mag_b;
  assign both_zero = cls_a.zero && cls_b.zero;

  always_comb begin
    eq = both_zero || (mag_eq && (cls_a.sign == cls_b.sign));
    if (both_zero) begin
      lt = 1'b0;
    end else if (cls_a.sign != cls_b.sign) begin
      lt = cls_a.sign;
    end else if (cls_a.sign) begin
      lt = mag_gt;
    end else begin
      lt = mag_lt;
    end
  end

endmodule

// File: rtl/fpcmp_pred.sv
module fpcmp_pred
  import fpcmp_pkg::*;
(
  input  logic       unord,
  input  logic       eq,
  input  logic       lt,
  input  logic [3:0] pred,
  output logic       hit
);

  logic ord_eq, ord_lt, ord_le;

  assign ord_eq = ~unord & eq;
  assign ord_lt = ~unord & lt;
  assign ord_le = ~unord & (lt | eq);

  always_comb begin
    case (pred)
      P_NEVER: hit = 1'b0;
      P_UNORD: hit = unord;
      P_EQ:    hit = ord_eq;
      P_UEQ:   hit = unord | ord_eq;
      P_LT:    hit = ord_lt;
      P_ULT:   hit = unord | ord_lt;
      P_LE:    hit = ord_le;
      P_ULE:   hit = unord | ord_le;
      P_ORD:   hit = ~unord;
      P_UNE:   hit = unord | ~ord_eq;
      P_NE:    hit = ~unord & ~eq;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/fp_pred_cmp.sv
module fp_pred_cmp
  import fpcmp_pkg::*;
#(
  parameter int ED = EXP_D,
  parameter int MD = MAN_D,
  parameter int ES = EXP_S,
  parameter int MS = MAN_S
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 prec_dbl,
  input  logic [3:0]           pred,
  input  logic                 cond_mode,
  input  logic [ED+MD:0]       op_a,
  input  logic [ED+MD:0]       op_b,
  output logic                 out_valid,
  output logic [ED+MD:0]       mask_out,
  output logic                 cond_out
);

  localparam int DW    = ED + MD + 1;
  localparam int SW    = ES + MS + 1;
  localparam int MAG_W = DW - 1;
  localparam int NOPS  = 2;

  logic [NOPS-1:0][DW-1:0] opnd;
  fp_cls_t                 cls_s   [NOPS];
  fp_cls_t                 cls_d   [NOPS];
  fp_cls_t                 cls_sel [NOPS];
  logic [MAG_W-1:0]        mag_s   [NOPS];
  logic [MAG_W-1:0]        mag_d   [NOPS];
  logic [MAG_W-1:0]        mag_sel [NOPS];

  assign opnd = {op_b, op_a};

  generate
    for (genvar i = 0; i < NOPS; i++) begin : g_op
      fpcmp_unpack #(.EW(ES), .MW(MS), .OUT_W(MAG_W)) u_sgl (
        .word (opnd[i][SW-1:0]),
        .cls  (cls_s[i]),
        .mag  (mag_s[i])
      );
      fpcmp_unpack #(.EW(ED), .MW(MD), .OUT_W(MAG_W)) u_dbl (
        .word (opnd[i]),
        .cls  (cls_d[i]),
        .mag  (mag_d[i])
      );
      assign cls_sel[i] = prec_dbl ? cls_d[i] : cls_s[i];
      assign mag_sel[i] = prec_dbl ? mag_d[i] : mag_s[i];
    end
  endgenerate

  logic rel_eq, rel_lt, unord, hit;

  fpcmp_order #(.MAG_W(MAG_W)) u_order (
    .cls_a (cls_sel[0]),
    .cls_b (cls_sel[1]),
    .mag_a (mag_sel[0]),
    .mag_b (mag_sel[1]),
    .eq    (rel_eq),
    .lt    (rel_lt)
  );

  assign unord = cls_sel[0].nan | cls_sel[1].nan;

  fpcmp_pred u_pred (
    .unord (unord),
    .eq    (rel_eq),
    .lt    (rel_lt),
    .pred  (pred),
    .hit   (hit)
  );

  logic [DW-1:0] full_mask;
  assign full_mask = prec_dbl ? {DW{1'b1}} : {{(DW-SW){1'b0}}, {SW{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      mask_out  <= '0;
      cond_out  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (cond_mode) begin
          cond_out <= hit;
        end else begin
          mask_out <= hit ? full_mask : '0;
        end
      end
    end
  end

endmodule

// File: rtl/fpcmp_chk.sv
module fpcmp_chk #(
  parameter int DW = 64,
  parameter int SW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          prec_dbl,
  input logic [3:0]    pred,
  input logic          cond_mode,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic          out_valid,
  input logic [DW-1:0] mask_out,
  input logic          cond_out
);

  logic a_dnan, b_dnan;
  assign a_dnan = (&op_a[DW-2:52]) && (|op_a[51:0]);
  assign b_dnan = (&op_b[DW-2:52]) && (|op_b[51:0]);

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2
  mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_out == '0) || (mask_out == {DW{1'b1}}) ||
    (mask_out == {{(DW-SW){1'b0}}, {SW{1'b1}}}));

  // R2
  single_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_mode && !prec_dbl) |=> (mask_out[DW-1:SW] == '0));

  // R3
  never_pred_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_mode && pred == 4'd0) |=> (mask_out == '0));

  // R4
  unord_nan_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_mode && prec_dbl && pred == 4'd1 && (a_dnan || b_dnan))
    |=> (mask_out == {DW{1'b1}}));

  // R11
  cond_holds_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_mode) |=> $stable(mask_out));

  // R12
  mask_holds_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_mode) |=> $stable(cond_out));

  // R12
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(cond_out) && $stable(mask_out)));

endmodule

bind fp_pred_cmp fpcmp_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .prec_dbl  (prec_dbl),
  .pred      (pred),
  .cond_mode (cond_mode),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .mask_out  (mask_out),
  .cond_out  (cond_out)
);

// File: tb/tb_fp_pred_cmp.sv
module tb_fp_pred_cmp;

  localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] D_TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] D_NEG1 = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] D_NEG2 = 64'hC000_0000_0000_0000;
  localparam logic [63:0] D_PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] D_NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] D_SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] D_PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] D_NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] D_TINY = 64'h0000_0000_0000_0001;
  localparam logic [31:0] S_ONE  = 32'h3F80_0000;
  localparam logic [31:0] S_TWO  = 32'h4000_0000;
  localparam logic [31:0] S_NEG2 = 32'hC000_0000;
  localparam logic [31:0] S_NAN  = 32'h7FC0_0000;
  localparam logic [31:0] S_NZ   = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        prec_dbl = 1'b1;
  logic [3:0]  pred = 4'd0;
  logic        cond_mode = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        out_valid;
  logic [63:0] mask_out;
  logic        cond_out;

  int nvec = 0;
  int nfail = 0;
  logic [63:0] last_mask = '0;
  logic        last_cc = 1'b0;

  always #2 clk = ~clk;

  fp_pred_cmp dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .prec_dbl  (prec_dbl),
    .pred      (pred),
    .cond_mode (cond_mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .mask_out  (mask_out),
    .cond_out  (cond_out)
  );

  function automatic logic model(bit dbl, logic [3:0] p, logic [63:0] a, logic [63:0] b);
    logic na, nb, un, eq, lt;
    longint va, vb;
    if (dbl) begin
      na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
      nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
      va = a[63] ? -longint'({1'b0, a[62:0]}) : longint'({1'b0, a[62:0]});
      vb = b[63] ? -longint'({1'b0, b[62:0]}) : longint'({1'b0, b[62:0]});
    end else begin
      na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
      nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
      va = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
      vb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
    end
    un = na | nb;
    eq = !un && (va == vb);
    lt = !un && (va < vb);
    case (p)
      4'd1:  return un;
      4'd2:  return eq;
      4'd3:  return un | eq;
      4'd4:  return lt;
      4'd5:  return un | lt;
      4'd6:  return lt | eq;
      4'd7:  return un | lt | eq;
      4'd9:  return !un;
      4'd10: return un | !eq;
      4'd11: return !un && !eq;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] p);
    case (p)
      4'd0: return "R3";
      4'd1, 4'd9: return "R4";
      4'd2, 4'd4, 4'd6: return "R5";
      4'd3, 4'd5, 4'd7: return "R6";
      4'd10, 4'd11: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(bit dbl, logic [3:0] p, bit cc, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; prec_dbl = dbl; pred = p; cond_mode = cc; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Every code in mask mode on one pair; the whole 64-bit mask is compared (R2).
  task automatic sweep(string extra, bit dbl, logic [63:0] a, logic [63:0] b);
    for (int p = 0; p < 16; p++) begin
      logic [63:0] exp;
      apply(dbl, 4'(p), 1'b0, a, b);
      exp = model(dbl, 4'(p), a, b) ? (dbl ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF) : 64'h0;
      check({tag_of(4'(p)), extra}, mask_out, exp);
      check("R1 valid", {63'h0, out_valid}, 64'h1);
      last_mask = exp;
    end
  endtask

  task automatic t_reset;
    check("R13 valid", {63'h0, out_valid}, 64'h0);
    check("R13 mask", mask_out, 64'h0);
    check("R13 cc", {63'h0, cond_out}, 64'h0);
  endtask

  task automatic t_ordered;
    sweep(" lt", 1'b1, D_ONE, D_TWO);
    sweep(" eq", 1'b1, D_TWO, D_TWO);
    sweep(" gt", 1'b1, D_TWO, D_ONE);
  endtask

  task automatic t_nan;
    sweep(" qnan-a", 1'b1, D_QNAN, D_ONE);
    sweep(" snan-b", 1'b1, D_ONE, D_SNAN);
    sweep(" both-nan", 1'b1, D_QNAN, D_QNAN);
    sweep(" inf-not-nan", 1'b1, D_PINF, D_PINF);
  endtask

  task automatic t_zero_sign;
    sweep(" R8 zeros", 1'b1, D_PZ, D_NZ);
    sweep(" R8 zeros-r", 1'b1, D_NZ, D_PZ);
    sweep(" R9 neg-pos", 1'b1, D_NEG1, D_ONE);
    sweep(" R9 neg-neg", 1'b1, D_NEG2, D_NEG1);
    sweep(" R9 ninf", 1'b1, D_NINF, D_NEG2);
    sweep(" R9 tiny-negz", 1'b1, D_NZ, D_TINY);
  endtask

  task automatic t_single;
    sweep(" R2 single lt", 1'b0, {32'hDEAD_BEEF, S_ONE}, {32'h1234_5678, S_TWO});
    sweep(" R2 single neg", 1'b0, {32'hFFFF_FFFF, S_NEG2}, {32'h0, S_ONE});
    sweep(" R2 single nan", 1'b0, {32'h0, S_NAN}, {32'h7FF8_0000, S_ONE});
    sweep(" R8 single zeros", 1'b0, {32'hABCD_0000, S_NZ}, 64'h0);
  endtask

  task automatic t_cond_mode;
    logic e;
    // Seed the mask with a known non-zero value.
    apply(1'b1, 4'd9, 1'b0, D_ONE, D_TWO);
    last_mask = {64{1'b1}};
    check("R2 seed", mask_out, last_mask);
    for (int p = 0; p < 12; p++) begin
      apply(1'b1, 4'(p), 1'b1, D_QNAN, D_ONE);
      e = model(1'b1, 4'(p), D_QNAN, D_ONE);
      check("R11 cc nan", {63'h0, cond_out}, {63'h0, e});
      check("R11 mask held", mask_out, last_mask);
      last_cc = e;
    end
    apply(1'b1, 4'd6, 1'b1, D_NEG1, D_NZ);
    check("R11 cc le", {63'h0, cond_out}, 64'h1);
    apply(1'b1, 4'd0, 1'b1, D_ONE, D_ONE);
    check("R11 R3 cc never", {63'h0, cond_out}, 64'h0);
    apply(1'b1, 4'd1, 1'b1, D_ONE, D_SNAN);
    check("R11 R4 cc unord", {63'h0, cond_out}, 64'h1);
    last_cc = 1'b1;
  endtask

  task automatic t_hold;
    apply(1'b1, 4'd2, 1'b0, D_ONE, D_TWO);
    check("R12 cc held by mask op", {63'h0, cond_out}, {63'h0, last_cc});
    check("R12 mask written", mask_out, 64'h0);
    @(negedge clk);
    in_valid = 1'b0; pred = 4'd9; cond_mode = 1'b1; op_a = D_ONE; op_b = D_ONE;
    @(negedge clk);
    check("R1 idle", {63'h0, out_valid}, 64'h0);
    check("R12 idle mask", mask_out, 64'h0);
    check("R12 idle cc", {63'h0, cond_out}, {63'h0, last_cc});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_ordered;
    t_nan;
    t_zero_sign;
    t_single;
    t_cond_mode;
    t_hold;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nvec++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule